// File: doc/BRIEF.md
# Leave-One-Out Product Unit for Check-Node Updates

This block performs the check-node update of an iterative belief-propagation decoder. It takes the messages arriving at one check node as a serial stream. For each neighbour, it returns the product of every other message, so that neighbour's own message is excluded. It never divides by a total. Instead it builds the results from a prefix pass and a suffix pass over partial products. Each incoming message is read from the stream exactly once and kept in a small local store.

During the load phase, each accepted message is written into the local store. At the same time the running prefix product is recorded and then extended by that message. After the final message of a group, the block walks the store from the highest index down to index 0 and records the suffix products. It then combines each prefix with its matching suffix and emits the results, one per cycle, in input order. All arithmetic sits in one combine module, so a different half-iteration could reuse the same structure by replacing that module alone. Messages are unsigned Q0.16 fractions, and the all-ones code stands for 1.0.

Top module: `fb_extrinsic_unit`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_last is 0.
- R2: The combine operation on 16-bit codes a and b gives b when a is 0xFFFF, gives a when b is 0xFFFF, and otherwise gives bits [31:16] of the 32-bit product a*b (truncation).
- R3: For a group of n messages x0..x(n-1), output k is combine(P_k, S_k). P_k is x0..x(k-1) folded left to right from 0xFFFF. S_k is x(n-1) down to x(k+1) folded from 0xFFFF, highest index first. An empty fold is 0xFFFF, so a one-message group gives 0xFFFF.
- R4: A zero message makes every other output of its group zero. Its own output still equals the product of the other messages as given in R3.
- R5: A group ends on the accepted message that has in_last=1, or on the sixth accepted message, whichever comes first. Exactly one output is produced for each accepted message.
- R6: The first output appears n+1 clock cycles after the edge that accepts the group's final message. The remaining outputs follow on consecutive cycles, in input order.
- R7: out_last is 1 only together with the final output of a group.
- R8: in_ready is 0 from the edge that accepts a group's final message until the edge that presents that group's final output, and it is 1 again in that cycle. While in_ready is 0, in_valid has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A message is offered |
| in_ready | output | 1 | The block accepts messages (load phase) |
| in_data | input | 16 | Q0.16 message |
| in_last | input | 1 | Final message of the group |
| out_valid | output | 1 | out_data holds a result |
| out_data | output | 16 | Leave-one-out product |
| out_last | output | 1 | Final result of the group |

## Verification
Take a group of n messages whose final message is accepted at edge E. No output is due for the n cycles after E. The results are due in the cycles after edges E+n+1 through E+2n, and in_ready returns in the last of those cycles. The bench counts its cycles from the edge that accepts the final message. It samples on the falling edge at exactly those points: it first checks that out_valid is low through the suffix pass, then compares each result, its out_last flag and in_ready in the cycle where that output is due. During the busy window it holds in_valid high with junk data, so any message taken while in_ready is low would show up in the expected values.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_BACK = 2'd1,
        PH_EMIT = 2'd2
    } fbx_phase_t;
endpackage

// File: rtl/fbx_combine.sv
// Operation-specific combine: Q0.16 product with all-ones treated as exact 1.0.
module fbx_combine #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] ONE = {W{1'b1}};

    logic [2*W-1:0] full;

    always_comb begin
        full = a * b;
        if (a == ONE) begin
            y = b;
        end else if (b == ONE) begin
            y = a;
        end else begin
            y = full[2*W-1:W];
        end
    end
endmodule

// File: rtl/fbx_regfile.sv
// Small register store: one write port, one combinational read port.
module fbx_regfile #(
    parameter int N  = 6,
    parameter int W  = 16,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [N];
    logic [W-1:0] mem_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            mem_d[i] = mem_q[i];
            if (we && (waddr == AW'(i))) begin
                mem_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = (raddr < AW'(N)) ? mem_q[raddr] : '0;
endmodule

// File: rtl/fb_extrinsic_unit.sv
module fb_extrinsic_unit #(
    parameter int DEG = 6,
    parameter int W   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    import fbx_pkg::*;

    localparam int IW = (DEG > 1) ? $clog2(DEG) : 1;
    localparam logic [W-1:0]  ONE  = {W{1'b1}};
    localparam logic [IW-1:0] TOP  = IW'(DEG - 1);

    typedef struct packed {
        fbx_phase_t    phase;
        logic [IW-1:0] idx;
        logic [IW-1:0] last_idx;
        logic [W-1:0]  prefix;
        logic [W-1:0]  suffix;
        logic          out_valid;
        logic          out_last;
        logic [W-1:0]  out_data;
    } state_t;

    state_t st_q, st_d;

    // store control
    logic          msg_we, fwd_we, bwd_we;
    logic [IW-1:0] msg_raddr, pair_raddr;
    logic [W-1:0]  msg_rd, fwd_rd, bwd_rd;
    logic [W-1:0]  prefix_next, suffix_next, pair_prod;

    fbx_regfile #(.N(DEG), .W(W)) u_msg (
        .clk(clk), .rst_n(rst_n), .we(msg_we), .waddr(st_q.idx),
        .wdata(in_data), .raddr(msg_raddr), .rdata(msg_rd)
    );

    fbx_regfile #(.N(DEG), .W(W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .we(fwd_we), .waddr(st_q.idx),
        .wdata(st_q.prefix), .raddr(pair_raddr), .rdata(fwd_rd)
    );

    fbx_regfile #(.N(DEG), .W(W)) u_bwd (
        .clk(clk), .rst_n(rst_n), .we(bwd_we), .waddr(st_q.idx),
        .wdata(st_q.suffix), .raddr(pair_raddr), .rdata(bwd_rd)
    );

    fbx_combine #(.W(W)) u_prefix_mul (
        .a(st_q.prefix), .b(in_data), .y(prefix_next)
    );

    fbx_combine #(.W(W)) u_suffix_mul (
        .a(st_q.suffix), .b(msg_rd), .y(suffix_next)
    );

    fbx_combine #(.W(W)) u_pair_mul (
        .a(fwd_rd), .b(bwd_rd), .y(pair_prod)
    );

    assign msg_raddr  = st_q.idx;
    assign pair_raddr = st_q.idx;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.out_last  = 1'b0;
        msg_we         = 1'b0;
        fwd_we         = 1'b0;
        bwd_we         = 1'b0;

        unique case (st_q.phase)
            PH_LOAD: begin
                if (in_valid) begin
                    msg_we      = 1'b1;
                    fwd_we      = 1'b1;
                    st_d.prefix = prefix_next;
                    if (in_last || (st_q.idx == TOP)) begin
                        st_d.phase    = PH_BACK;
                        st_d.last_idx = st_q.idx;
                        st_d.suffix   = ONE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            PH_BACK: begin
                bwd_we      = 1'b1;
                st_d.suffix = suffix_next;
                if (st_q.idx == '0) begin
                    st_d.phase = PH_EMIT;
                end else begin
                    st_d.idx = st_q.idx - 1'b1;
                end
            end
            PH_EMIT: begin
                st_d.out_valid = 1'b1;
                st_d.out_data  = pair_prod;
                if (st_q.idx == st_q.last_idx) begin
                    st_d.out_last = 1'b1;
                    st_d.phase    = PH_LOAD;
                    st_d.idx      = '0;
                    st_d.prefix   = ONE;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_LOAD;
                st_d.idx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_LOAD;
            st_q.idx       <= '0;
            st_q.last_idx  <= '0;
            st_q.prefix    <= ONE;
            st_q.suffix    <= ONE;
            st_q.out_valid <= 1'b0;
            st_q.out_last  <= 1'b0;
            st_q.out_data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = (st_q.phase == PH_LOAD);
    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
    assign out_last  = st_q.out_last;

    // R7: the group-end flag never appears without a result
    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6: results of one group leave on consecutive cycles
    a_r6_outputs_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R8: no message is taken while results are still pending
    a_r8_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    // R8: accepting a flagged final message closes the input
    a_r8_ready_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R6: nothing is emitted right after the final message is taken
    a_r6_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !out_valid);
endmodule

// File: tb/fb_extrinsic_unit_test.sv
module fb_extrinsic_unit_test;
    localparam int DEG = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] vals [DEG];

    always #2.5 clk = ~clk;

    fb_extrinsic_unit #(.DEG(DEG), .W(16)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // R2 combine rule
    function automatic logic [15:0] qmul(logic [15:0] a, logic [15:0] b);
        logic [31:0] p;
        p = 32'(a) * 32'(b);
        if (a == 16'hFFFF) return b;
        if (b == 16'hFFFF) return a;
        return p[31:16];
    endfunction

    // R3 expected leave-one-out result
    function automatic logic [15:0] expect_out(int n, int k);
        logic [15:0] p, s;
        p = 16'hFFFF;
        s = 16'hFFFF;
        for (int j = 0; j < k; j++) p = qmul(p, vals[j]);
        for (int j = n - 1; j > k; j--) s = qmul(s, vals[j]);
        return qmul(p, s);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one group; flag_last=0 and n=DEG relies on the sixth-message end (R5)
    task automatic run_group(int n, bit flag_last, bit gaps);
        for (int k = 0; k < n; k++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            @(negedge clk);
            check("R8 ready while loading", 32'(in_ready), 32'd1);
            in_valid = 1'b1;
            in_data  = vals[k];
            in_last  = (k == n - 1) && flag_last;
        end
        // edge E accepts the final message
        @(negedge clk);
        // junk offered while busy must be ignored (R8)
        in_valid = 1'b1;
        in_data  = 16'h1234;
        in_last  = 1'b0;
        check("R8 ready low after last", 32'(in_ready), 32'd0);
        check("R6 no output at E+0", 32'(out_valid), 32'd0);
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            check("R6 no output during suffix pass", 32'(out_valid), 32'd0);
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R6 output valid in its cycle", 32'(out_valid), 32'd1);
            check("R3 R4 result value", 32'(out_data), 32'(expect_out(n, k)));
            check("R7 last flag", 32'(out_last), 32'(k == n - 1));
            check("R8 ready timing", 32'(in_ready), 32'(k == n - 1));
            if (k == n - 1) begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R5 R7 no extra output", 32'(out_valid), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        check("R1 ready after reset", 32'(in_ready), 32'd1);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
        check("R1 last after reset", 32'(out_last), 32'd0);
        rst_n = 1'b1;

        // R2/R3: all ones gives all ones
        for (int i = 0; i < DEG; i++) vals[i] = 16'hFFFF;
        run_group(DEG, 1'b1, 1'b0);

        // R2 truncation directed: 0x8000 halves
        for (int i = 0; i < DEG; i++) vals[i] = 16'h8000;
        run_group(DEG, 1'b1, 1'b0);

        // R4 single zero at index 2
        vals[0] = 16'hC000; vals[1] = 16'h9A3C; vals[2] = 16'h0000;
        vals[3] = 16'hFFFF; vals[4] = 16'h7123; vals[5] = 16'hE001;
        run_group(DEG, 1'b1, 1'b0);

        // R4 two zeros: every output zero
        vals[1] = 16'h0000;
        run_group(DEG, 1'b1, 1'b0);

        // R5 sixth message ends the group without in_last
        for (int i = 0; i < DEG; i++) vals[i] = 16'(16'hF000 - 16'(i * 16'h0300));
        run_group(DEG, 1'b0, 1'b0);

        // R3 one-message group gives 0xFFFF
        vals[0] = 16'h2222;
        run_group(1, 1'b1, 1'b0);

        // R5 short group ended by in_last
        vals[0] = 16'hAAAA; vals[1] = 16'h5555; vals[2] = 16'hFFFE;
        run_group(3, 1'b1, 1'b1);

        // random groups
        for (int g = 0; g < 40; g++) begin
            int n;
            n = $urandom_range(1, DEG);
            for (int i = 0; i < DEG; i++) begin
                case ($urandom_range(0, 9))
                    0: vals[i] = 16'h0000;
                    1: vals[i] = 16'hFFFF;
                    default: vals[i] = 16'($urandom);
                endcase
            end
            run_group(n, (n < DEG) ? 1'b1 : 1'($urandom_range(0, 1)), 1'b1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule